// File: doc/BRIEF.md
# Programmable Clock-Enable Divider with Bypass

The block divides a reference clock by a programmable ratio. Its output is a clock-enable that pulses for one reference cycle at the divided rate. Downstream logic stays on the reference clock and gates on this enable. An 8-bit divisor field sets the ratio. A field value of zero is decoded as 256.

Software asks for a new ratio by pulsing a request with the wanted divisor. The block then runs a safe reprogramming sequence:
- it forces bypass on at once;
- it writes the encoded divisor field on the next cycle;
- it keeps bypass on for a programmable number of reference cycles;
- it then releases bypass.

While bypass is active, the enable is high on every cycle, so the output runs at the undivided rate. An external bypass input has the same effect at any time. The block also reports the divisor that is actually in effect, which is 1 whenever any bypass is active.

Top module: `clkdiv_bypass`

## Requirements
- R1: The divisor field is `FIELD_W` (8) bits wide. A field value of 0 decodes to a ratio of 256. Any other value v decodes to v. Outside bypass, `eff_div_o` shows the decoded ratio.
- R2: With no bypass active and decoded ratio N, `clk_en_o` is high on exactly one cycle of every N consecutive reference cycles.
- R3: While `bypass_i` is high, `clk_en_o` is high on every cycle and `eff_div_o` reads 1, whatever the field holds.
- R4: A request value of 1 to 255 is stored in the field unchanged. A request value of 0, 256 or anything larger stores field value 0, the divide-by-256 encoding.
- R5: When a request is accepted on a clock edge, `bypass_o` and `busy_o` go high after that edge. The field takes the new value one edge later. Bypass is then held for `HOLD_CYC` further cycles. `busy_o` is high for exactly `HOLD_CYC`+1 cycles and falls together with `bypass_o`.
- R6: The new ratio N takes effect only when bypass is released, and it starts a fresh period. The first enable pulse after release comes on the Nth cycle after the release edge.
- R7: A request made while `busy_o` is high is ignored: the field value and the sequence timing do not change. It sets `err_o`, which stays high until the next accepted request clears it.
- R8: After reset the block is in bypass: `bypass_o` is 1, the field is 0, `busy_o` and `err_o` are 0, `clk_en_o` is 1 and `eff_div_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bypass_i | input | 1 | External bypass, passes the reference rate |
| req_i | input | 1 | Reprogram request, sampled on each edge |
| req_div_i | input | REQ_W (16) | Requested divisor, sampled with an accepted request |
| clk_en_o | output | 1 | One-cycle enable at the divided rate |
| bypass_o | output | 1 | Internal bypass held by the sequencer |
| busy_o | output | 1 | Reprogramming sequence in progress |
| err_o | output | 1 | Sticky flag for a request made while busy |
| div_field_o | output | FIELD_W (8) | Programmed divisor field |
| eff_div_o | output | FIELD_W+1 (9) | Ratio in effect: 1 in bypass, else the decoded field |

## Verification
The assertions assume that `bypass_i`, `req_i` and `req_div_i` are synchronous to the reference clock and settle before each rising edge. They also assume that reset is held across at least one edge, so that the first sampled history is the reset state. The stimulus changes every input shortly after a falling edge and holds `req_i` for exactly one cycle per request. Requests made while busy and toggles of `bypass_i` are placed at chosen points inside and outside the hold window.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/clkdiv_reprog_seq.sv
module clkdiv_reprog_seq
  import clkdiv_pkg::*;
#(
  parameter int FIELD_W  = 8,
  parameter int REQ_W    = 16,
  parameter int HOLD_CYC = 25
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [REQ_W-1:0]   req_div_i,
  output logic               byp_o,
  output logic               busy_o,
  output logic               err_o,
  output logic [FIELD_W-1:0] field_o
);
  localparam int MAX_DIV = 1 << FIELD_W;
  localparam int HOLD_W  = $clog2(HOLD_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

  seq_state_e         state_q;
  logic [HOLD_W-1:0]  hold_q;
  logic [FIELD_W-1:0] pend_q, field_q, enc_d;
  logic               byp_q, err_q;

  // 0 and oversize requests both map to the divide-by-MAX encoding
  always_comb begin
    if (req_div_i == '0 || req_div_i >= REQ_W'(MAX_DIV)) enc_d = '0;
    else                                                   enc_d = req_div_i[FIELD_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      hold_q  <= '0;
      pend_q  <= '0;
      field_q <= '0;
      byp_q   <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (req_i) begin
            byp_q   <= 1'b1;
            pend_q  <= enc_d;
            err_q   <= 1'b0;
            state_q <= SEQ_LOAD;
          end
        end
        SEQ_LOAD: begin
          field_q <= pend_q;
          hold_q  <= '0;
          state_q <= SEQ_HOLD;
          if (req_i) err_q <= 1'b1;
        end
        SEQ_HOLD: begin
          if (hold_q == HOLD_LAST) begin
            byp_q   <= 1'b0;
            state_q <= SEQ_IDLE;
          end else begin
            hold_q <= hold_q + 1'b1;
          end
          if (req_i) err_q <= 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign byp_o   = byp_q;
  assign busy_o  = (state_q != SEQ_IDLE);
  assign err_o   = err_q;
  assign field_o = field_q;
endmodule

// File: rtl/clkdiv_rate_counter.sv
module clkdiv_rate_counter #(
  parameter int FIELD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byp_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic               en_o,
  output logic [FIELD_W:0]   act_o
);
  localparam int CNT_W = FIELD_W + 1;
  localparam logic [CNT_W-1:0] MAX_DIV = CNT_W'(1 << FIELD_W);

  logic [CNT_W-1:0] cnt_q, act_q, dec_d;
  logic             wrap;

  assign dec_d = (field_i == '0) ? MAX_DIV : {1'b0, field_i};
  assign wrap  = (cnt_q == act_q - 1'b1);

  // ratio is latched only in bypass or at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= MAX_DIV;
    end else if (byp_i || wrap) begin
      cnt_q <= '0;
      act_q <= dec_d;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en_o  = byp_i | wrap;
  assign act_o = act_q;
endmodule

// File: rtl/clkdiv_bypass.sv
module clkdiv_bypass #(
  parameter int FIELD_W  = 8,
  parameter int REQ_W    = 16,
  parameter int HOLD_CYC = 25
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bypass_i,
  input  logic               req_i,
  input  logic [REQ_W-1:0]   req_div_i,
  output logic               clk_en_o,
  output logic               bypass_o,
  output logic               busy_o,
  output logic               err_o,
  output logic [FIELD_W-1:0] div_field_o,
  output logic [FIELD_W:0]   eff_div_o
);
  logic               seq_byp, byp_any;
  logic [FIELD_W-1:0] field;
  logic [FIELD_W:0]   act;

  clkdiv_reprog_seq #(
    .FIELD_W (FIELD_W),
    .REQ_W   (REQ_W),
    .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .req_div_i(req_div_i),
    .byp_o    (seq_byp),
    .busy_o   (busy_o),
    .err_o    (err_o),
    .field_o  (field)
  );

  assign byp_any = seq_byp | bypass_i;

  clkdiv_rate_counter #(
    .FIELD_W(FIELD_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .byp_i  (byp_any),
    .field_i(field),
    .en_o   (clk_en_o),
    .act_o  (act)
  );

  assign bypass_o    = seq_byp;
  assign div_field_o = field;
  assign eff_div_o   = byp_any ? (FIELD_W+1)'(1) : act;
endmodule

// File: rtl/clkdiv_bypass_chk.sv
module clkdiv_bypass_chk #(
  parameter int FIELD_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bypass_i,
  input logic               req_i,
  input logic               clk_en_o,
  input logic               bypass_o,
  input logic               busy_o,
  input logic               err_o,
  input logic [FIELD_W-1:0] div_field_o,
  input logic [FIELD_W:0]   eff_div_o
);
  // R3
  ext_bypass_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> (clk_en_o && eff_div_o == 1));

  // R5
  busy_in_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bypass_o);

  // R5
  release_with_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bypass_o) |-> $fell(busy_o));

  // R7
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(req_i) && $past(busy_o)));

  // R4
  field_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_o) |-> $stable(div_field_o));

  // R1
  eff_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_div_o != '0);

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && !bypass_i && !bypass_o && eff_div_o > 1) |=>
      (!clk_en_o || bypass_i || bypass_o));
endmodule

bind clkdiv_bypass clkdiv_bypass_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bypass_i   (bypass_i),
  .req_i      (req_i),
  .clk_en_o   (clk_en_o),
  .bypass_o   (bypass_o),
  .busy_o     (busy_o),
  .err_o      (err_o),
  .div_field_o(div_field_o),
  .eff_div_o  (eff_div_o)
);

// File: tb/clkdiv_bypass_bench.sv
module clkdiv_bypass_bench;
  localparam int FIELD_W = 8;
  localparam int REQ_W   = 16;
  localparam int HOLD    = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bypass = 1'b0, req = 1'b0;
  logic [REQ_W-1:0] req_div = '0;
  logic clk_en, byp_o, busy, err;
  logic [FIELD_W-1:0] field;
  logic [FIELD_W:0] eff;

  int n_chk = 0, n_err = 0;
  int m_byp = 1, m_busy = 0, m_stage = 0, m_hold = 0, m_pend = 0;
  int m_field = 0, m_act = 256, m_cnt = 0, m_err = 0;
  bit run_cmp = 0;

  always #4 clk = ~clk;

  clkdiv_bypass #(.FIELD_W(FIELD_W), .REQ_W(REQ_W), .HOLD_CYC(HOLD)) u_clkdiv_bypass (
    .clk_i(clk), .rst_ni(rst_n), .bypass_i(bypass), .req_i(req), .req_div_i(req_div),
    .clk_en_o(clk_en), .bypass_o(byp_o), .busy_o(busy), .err_o(err),
    .div_field_o(field), .eff_div_o(eff)
  );

  function automatic int enc(int v);
    return (v == 0 || v >= 256) ? 0 : v;
  endfunction
  function automatic int dec(int f);
    return (f == 0) ? 256 : f;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      int o_byp, o_field;
      o_byp = m_byp; o_field = m_field;
      case (m_stage)
        0: if (req) begin
             m_byp = 1; m_busy = 1; m_stage = 1; m_pend = enc(int'(req_div)); m_err = 0;
           end
        1: begin m_field = m_pend; m_stage = 2; m_hold = 0; if (req) m_err = 1; end
        default: begin
          if (m_hold == HOLD - 1) begin m_byp = 0; m_busy = 0; m_stage = 0; end
          else m_hold++;
          if (req) m_err = 1;
        end
      endcase
      if (o_byp != 0 || bypass) begin m_cnt = 0; m_act = dec(o_field); end
      else if (m_cnt == m_act - 1) begin m_cnt = 0; m_act = dec(o_field); end
      else m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      bit any_byp;
      int e_en, e_eff;
      any_byp = (m_byp != 0) || bypass;
      e_en  = any_byp ? 1 : (m_cnt == m_act - 1 ? 1 : 0);
      e_eff = any_byp ? 1 : m_act;
      chk(int'(clk_en) == e_en, "R2 clk_en_o", int'(clk_en), e_en);
      chk(int'(eff) == e_eff, "R1 eff_div_o", int'(eff), e_eff);
      chk(int'(byp_o) == m_byp, "R5 bypass_o", int'(byp_o), m_byp);
      chk(int'(busy) == m_busy, "R5 busy_o", int'(busy), m_busy);
      chk(int'(err) == m_err, "R7 err_o", int'(err), m_err);
      chk(int'(field) == m_field, "R4 div_field_o", int'(field), m_field);
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(int d);
    @(negedge clk); #1;
    req = 1'b1; req_div = REQ_W'(d);
    @(negedge clk); #1;
    req = 1'b0;
  endtask

  // counts enable pulses over a window, sampling at falling edges
  task automatic count_pulses(int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_en) pulses++;
    end
  endtask

  task automatic program_div(int d, int exp_field);
    int busy_cyc, first;
    @(negedge clk); #1;
    req = 1'b1; req_div = REQ_W'(d);
    busy_cyc = 0;
    @(negedge clk); #1;
    req = 1'b0;
    if (busy) busy_cyc++;
    while (busy && busy_cyc < HOLD + 10) begin
      @(negedge clk);
      if (busy) busy_cyc++;
    end
    chk(busy_cyc == HOLD + 1, "R5 busy length", busy_cyc, HOLD + 1);
    chk(int'(field) == exp_field, "R4 field after request", int'(field), exp_field);
    // now at first falling edge after release
    first = clk_en ? 1 : 0;
    for (int i = 2; i <= dec(exp_field) && first == 0; i++) begin
      @(negedge clk);
      if (clk_en) first = i;
    end
    chk(first == dec(exp_field), "R6 first pulse after release", first, dec(exp_field));
  endtask

  initial begin
    int p;
    cyc(4);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(clk_en && byp_o && !busy && !err && field == 0 && eff == 1, "R8 reset state",
        int'({clk_en, byp_o, busy, err}), 4'b1100);
    run_cmp = 1;

    program_div(4, 4);
    count_pulses(16, p);
    chk(p == 4, "R2 pulses div 4", p, 4);

    program_div(1, 1);
    count_pulses(10, p);
    chk(p == 10, "R2 pulses div 1", p, 10);

    program_div(3, 3);
    count_pulses(12, p);
    chk(p == 4, "R2 pulses div 3", p, 4);

    program_div(0, 0);
    chk(int'(eff) == 256, "R1 zero field decodes 256", int'(eff), 256);
    count_pulses(512, p);
    chk(p == 2, "R1 pulses div 256", p, 2);

    program_div(300, 0);
    program_div(256, 0);
    program_div(255, 255);
    chk(int'(eff) == 255, "R1 eff 255", int'(eff), 255);

    program_div(5, 5);
    cyc(7);
    @(negedge clk); #1 bypass = 1'b1;
    count_pulses(6, p);
    chk(p == 6, "R3 bypass pulses every cycle", p, 6);
    chk(int'(eff) == 1, "R3 eff in bypass", int'(eff), 1);
    @(negedge clk); #1 bypass = 1'b0;
    cyc(20);

    // request while busy is ignored
    request(6);
    cyc(3);
    request(9);
    chk(err == 1'b1, "R7 err set", int'(err), 1);
    cyc(HOLD + 5);
    chk(int'(field) == 6, "R7 ignored request", int'(field), 6);
    chk(err == 1'b1, "R7 err sticky", int'(err), 1);
    count_pulses(18, p);
    chk(p == 3, "R7 ratio kept", p, 3);
    program_div(2, 2);
    chk(err == 1'b0, "R7 err cleared", int'(err), 0);
    cyc(10);

    run_cmp = 0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule